// File: doc/BRIEF.md
# Banked Memory Chip-Select Decoder

This block turns a 20-bit processor address, a high-byte enable strobe and the read and write strobes into active-low chip selects for a 16-bit memory. The memory is built as two byte-wide banks: one holds the even bytes on data bits 7..0, the other holds the odd bytes on data bits 15..8. The bank pair answers in one 64 KB region out of the sixteen regions of the 1 MB space. A 4-bit input picks that region at run time, so the same decoder can place the pair anywhere.

A second path covers the topmost region, F0000h to FFFFFh. It is split into eight read-only blocks of 8 KB, and one active-low select goes to each block. The block also drives the memory output enable and write enable so that the two are never low together. It raises a flag when a word access starts at an odd address, which tells the bus logic that a two-cycle split is needed.

Parameters set the address width, the region and block field widths, whether the region compare uses all four top bits or only the upper three, and whether the read-only path is built.

Top module: `banked_cs_decoder`

## Requirements
- R1: With full decoding, the bank pair is hit only when addr_i[19:16] equals region_code_i. Code 4'b1110 covers E0000h to EFFFFh and code 4'b1100 covers C0000h to CFFFFh.
- R2: even_cs_n_o is low exactly when an access is active, the bank pair is hit and addr_i[0] is 0.
- R3: odd_cs_n_o is low exactly when an access is active, the bank pair is hit and bhe_n_i is 0. A word access at an even address (addr_i[0]=0, bhe_n_i=0) drives both bank selects low.
- R4: During a read with addr_i[19:16]=4'b1111, blk_cs_n_o[k] is low only for k = addr_i[15:13], so bit k covers F0000h + k*2000h up to 8 KB above that. All other bits stay high.
- R5: When the read-only path is built, an address in region 4'b1111 never selects a byte bank, even if region_code_i is 4'b1111.
- R6: mem_oe_n_o is low exactly when rd_n_i is low and wr_n_i is high. mem_we_n_o is low exactly when wr_n_i is low and rd_n_i is high. The two are never low together.
- R7: When neither strobe is low, or both are low, every chip select and both memory enables are high and misaligned_o is low.
- R8: misaligned_o is high exactly when an access is active, word_i is 1 and addr_i[0] is 1.
- R9: With partial decoding, only addr_i[19:17] is compared with region_code_i[3:1]. With code 4'b1110, the bank pair then spans E0000h to FFFFFh, which is 128 KB.
- R10: A write into region 4'b1111 drives no block select low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| addr_i | input | 20 | Byte address from the processor |
| bhe_n_i | input | 1 | High-byte enable, active low |
| rd_n_i | input | 1 | Read strobe, active low |
| wr_n_i | input | 1 | Write strobe, active low |
| word_i | input | 1 | The access is meant as a 16-bit word |
| region_code_i | input | 4 | Region code for the bank pair |
| even_cs_n_o | output | 1 | Even-byte bank select, active low |
| odd_cs_n_o | output | 1 | Odd-byte bank select, active low |
| blk_cs_n_o | output | 8 | Read-only block selects, active low |
| mem_oe_n_o | output | 1 | Memory output enable, active low |
| mem_we_n_o | output | 1 | Memory write enable, active low |
| misaligned_o | output | 1 | Word access starts at an odd address |

## Verification
The bench builds two copies of the decoder side by side on the same inputs. The first uses four-bit region compare with the read-only path, which covers the region sweep, the block selects and the priority of region 4'b1111 over a bank pair placed there. The second compares only three bits and leaves the read-only path out, so the 128 KB bank-pair span and its treatment of address bit 16 as don't-care can be checked. Every region code is swept against random addresses and strobe mixes, and directed cases add the word, byte, misaligned and conflicting-strobe corners.

// File: rtl/banked_cs_pkg.sv
package banked_cs_pkg;

   localparam int unsigned DEF_ADDR_W   = 20;
   localparam int unsigned DEF_REGION_W = 4;
   localparam int unsigned DEF_BLK_W    = 3;

   typedef enum logic [1:0] {
      ACC_IDLE  = 2'b00,
      ACC_READ  = 2'b01,
      ACC_WRITE = 2'b10,
      ACC_CLASH = 2'b11
   } acc_kind_e;

   function automatic acc_kind_e classify(input logic rd_n, input logic wr_n);
      return acc_kind_e'({~wr_n, ~rd_n});
   endfunction

endpackage

// File: rtl/region_match.sv
module region_match #(
   parameter int unsigned REGION_W    = 4,
   parameter bit          FULL_DECODE = 1'b1
) (
   input  logic [REGION_W-1:0] top_bits_i,
   input  logic [REGION_W-1:0] code_i,
   output logic                hit_o
);
   logic [REGION_W-1:0] cmp_mask;

   generate
      if (FULL_DECODE) begin : g_full
         assign cmp_mask = '1;
      end else begin : g_partial
         assign cmp_mask = {{(REGION_W-1){1'b1}}, 1'b0};
      end
   endgenerate

   assign hit_o = ((top_bits_i ^ code_i) & cmp_mask) == '0;
endmodule

// File: rtl/lane_select.sv
module lane_select (
   input  logic en_i,
   input  logic a0_i,
   input  logic bhe_n_i,
   output logic even_cs_n_o,
   output logic odd_cs_n_o
);
   assign even_cs_n_o = ~(en_i & ~a0_i);
   assign odd_cs_n_o  = ~(en_i & ~bhe_n_i);
endmodule

// File: rtl/block_decoder.sv
module block_decoder #(
   parameter int unsigned SEL_W = 3,
   localparam int unsigned OUT_N = 1 << SEL_W
) (
   input  logic             en_i,
   input  logic [SEL_W-1:0] sel_i,
   output logic [OUT_N-1:0] cs_n_o
);
   generate
      for (genvar k = 0; k < OUT_N; k++) begin : g_out
         assign cs_n_o[k] = ~(en_i && (sel_i == SEL_W'(k)));
      end
   endgenerate
endmodule

// File: rtl/banked_cs_decoder.sv
module banked_cs_decoder
   import banked_cs_pkg::*;
#(
   parameter int unsigned ADDR_W      = DEF_ADDR_W,
   parameter int unsigned REGION_W    = DEF_REGION_W,
   parameter int unsigned BLK_W       = DEF_BLK_W,
   parameter bit          FULL_DECODE = 1'b1,
   parameter bit          ROM_EN      = 1'b1,
   localparam int unsigned BLK_N      = 1 << BLK_W,
   localparam int unsigned REGION_LO  = ADDR_W - REGION_W,
   localparam int unsigned BLK_LO     = REGION_LO - BLK_W
) (
   input  logic [ADDR_W-1:0]   addr_i,
   input  logic                bhe_n_i,
   input  logic                rd_n_i,
   input  logic                wr_n_i,
   input  logic                word_i,
   input  logic [REGION_W-1:0] region_code_i,
   output logic                even_cs_n_o,
   output logic                odd_cs_n_o,
   output logic [BLK_N-1:0]    blk_cs_n_o,
   output logic                mem_oe_n_o,
   output logic                mem_we_n_o,
   output logic                misaligned_o
);
   generate
      if (REGION_W < 2 || BLK_W < 1 || BLK_LO < 2) begin : g_bad_widths
         $error("banked_cs_decoder: address too narrow for region and block fields");
      end
   endgenerate

   acc_kind_e kind;
   logic      active, reading, writing;
   logic      region_hit, rom_region, pair_en, rom_en;

   assign kind    = classify(rd_n_i, wr_n_i);
   assign reading = (kind == ACC_READ);
   assign writing = (kind == ACC_WRITE);
   assign active  = reading | writing;

   region_match #(.REGION_W(REGION_W), .FULL_DECODE(FULL_DECODE)) u_pair_match (
      .top_bits_i (addr_i[ADDR_W-1:REGION_LO]),
      .code_i     (region_code_i),
      .hit_o      (region_hit)
   );

   generate
      if (ROM_EN) begin : g_rom
         assign rom_region = &addr_i[ADDR_W-1:REGION_LO];
      end else begin : g_no_rom
         assign rom_region = 1'b0;
      end
   endgenerate

   assign pair_en = active & region_hit & ~rom_region;
   assign rom_en  = reading & rom_region;

   lane_select u_lanes (
      .en_i        (pair_en),
      .a0_i        (addr_i[0]),
      .bhe_n_i     (bhe_n_i),
      .even_cs_n_o (even_cs_n_o),
      .odd_cs_n_o  (odd_cs_n_o)
   );

   block_decoder #(.SEL_W(BLK_W)) u_blocks (
      .en_i   (rom_en),
      .sel_i  (addr_i[REGION_LO-1:BLK_LO]),
      .cs_n_o (blk_cs_n_o)
   );

   assign mem_oe_n_o   = ~reading;
   assign mem_we_n_o   = ~writing;
   assign misaligned_o = active & word_i & addr_i[0];

   logic unused_addr_bits;
   assign unused_addr_bits = ^addr_i[BLK_LO-1:1];
endmodule

// File: rtl/banked_cs_chk.sv
module banked_cs_chk #(
   parameter int unsigned ADDR_W   = 20,
   parameter int unsigned REGION_W = 4,
   parameter int unsigned BLK_N    = 8
) (
   input logic [ADDR_W-1:0] addr_i,
   input logic              bhe_n_i,
   input logic              rd_n_i,
   input logic              wr_n_i,
   input logic              word_i,
   input logic              even_cs_n_o,
   input logic              odd_cs_n_o,
   input logic [BLK_N-1:0]  blk_cs_n_o,
   input logic              mem_oe_n_o,
   input logic              mem_we_n_o,
   input logic              misaligned_o
);
   logic known;
   assign known = !$isunknown({addr_i, bhe_n_i, rd_n_i, wr_n_i, word_i, even_cs_n_o,
                               odd_cs_n_o, blk_cs_n_o, mem_oe_n_o, mem_we_n_o, misaligned_o});

   always_comb begin
      if (known) begin
         // R6
         oe_we_excl_chk: assert (mem_oe_n_o | mem_we_n_o);
         // R4
         blk_onehot_chk: assert ($onehot0(~blk_cs_n_o));
         // R5
         target_excl_chk: assert ((&blk_cs_n_o) | (even_cs_n_o & odd_cs_n_o));
         // R7
         idle_quiet_chk: assert (!(rd_n_i == wr_n_i) ||
                                 (even_cs_n_o && odd_cs_n_o && (&blk_cs_n_o) && !misaligned_o));
         // R2
         even_lane_chk: assert (even_cs_n_o || !addr_i[0]);
         // R3
         odd_lane_chk: assert (odd_cs_n_o || !bhe_n_i);
         // R10
         rom_no_write_chk: assert ((&blk_cs_n_o) || (!rd_n_i && wr_n_i));
         // R8
         misalign_chk: assert (!misaligned_o || (word_i && addr_i[0]));
      end
   end
endmodule

bind banked_cs_decoder banked_cs_chk #(
   .ADDR_W(ADDR_W), .REGION_W(REGION_W), .BLK_N(BLK_N)
) u_chk (
   .addr_i(addr_i), .bhe_n_i(bhe_n_i), .rd_n_i(rd_n_i), .wr_n_i(wr_n_i), .word_i(word_i),
   .even_cs_n_o(even_cs_n_o), .odd_cs_n_o(odd_cs_n_o), .blk_cs_n_o(blk_cs_n_o),
   .mem_oe_n_o(mem_oe_n_o), .mem_we_n_o(mem_we_n_o), .misaligned_o(misaligned_o)
);

// File: tb/tb_banked_cs_decoder.sv
module tb_banked_cs_decoder;
   typedef struct packed {
      logic       even_n;
      logic       odd_n;
      logic [7:0] blk_n;
      logic       oe_n;
      logic       we_n;
      logic       mis;
   } outs_t;

   typedef struct {
      outs_t full_exp;
      outs_t part_exp;
      string tag;
   } item_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #10 clk = ~clk;

   logic [19:0] addr = '0;
   logic bhe_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, word = 1'b0;
   logic [3:0] code = 4'b1110;

   outs_t full_act, part_act;

   banked_cs_decoder dut (
      .addr_i(addr), .bhe_n_i(bhe_n), .rd_n_i(rd_n), .wr_n_i(wr_n), .word_i(word),
      .region_code_i(code), .even_cs_n_o(full_act.even_n), .odd_cs_n_o(full_act.odd_n),
      .blk_cs_n_o(full_act.blk_n), .mem_oe_n_o(full_act.oe_n), .mem_we_n_o(full_act.we_n),
      .misaligned_o(full_act.mis)
   );

   banked_cs_decoder #(.FULL_DECODE(1'b0), .ROM_EN(1'b0)) dut_part (
      .addr_i(addr), .bhe_n_i(bhe_n), .rd_n_i(rd_n), .wr_n_i(wr_n), .word_i(word),
      .region_code_i(code), .even_cs_n_o(part_act.even_n), .odd_cs_n_o(part_act.odd_n),
      .blk_cs_n_o(part_act.blk_n), .mem_oe_n_o(part_act.oe_n), .mem_we_n_o(part_act.we_n),
      .misaligned_o(part_act.mis)
   );

   int compared = 0;
   int mismatched = 0;
   item_t q[$];

   function automatic outs_t model(input logic [19:0] a, input logic bn, input logic r_n,
                                   input logic w_n, input logic wd, input logic [3:0] c,
                                   input bit full, input bit rom);
      outs_t o;
      logic rd, wr, act, hit, romr;
      rd   = !r_n && w_n;
      wr   = !w_n && r_n;
      act  = rd || wr;
      hit  = full ? (a[19:16] == c) : (a[19:17] == c[3:1]);
      romr = rom && (a[19:16] == 4'hF);
      o.even_n = !(act && hit && !romr && a[0] == 1'b0);
      o.odd_n  = !(act && hit && !romr && bn == 1'b0);
      o.blk_n  = 8'hFF;
      if (rd && romr) o.blk_n[a[15:13]] = 1'b0;
      o.oe_n = !rd;
      o.we_n = !wr;
      o.mis  = act && wd && a[0];
      return o;
   endfunction

   task automatic drive(input logic [19:0] a, input logic bn, input logic r_n,
                        input logic w_n, input logic wd, input logic [3:0] c, input string tag);
      item_t it;
      @(posedge clk);
      #1;
      addr = a; bhe_n = bn; rd_n = r_n; wr_n = w_n; word = wd; code = c;
      it.full_exp = model(a, bn, r_n, w_n, wd, c, 1'b1, 1'b1);
      it.part_exp = model(a, bn, r_n, w_n, wd, c, 1'b0, 1'b0);
      it.tag = tag;
      q.push_back(it);
   endtask

   always @(negedge clk) begin
      if (rst_n && q.size() > 0) begin
         item_t it;
         it = q.pop_front();
         compared++;
         if (full_act !== it.full_exp) begin
            mismatched++;
            $display("FAIL %s full decode: addr=%h code=%b actual=%b expected=%b",
                     it.tag, addr, code, full_act, it.full_exp);
         end
         compared++;
         if (part_act !== it.part_exp) begin
            mismatched++;
            $display("FAIL %s partial decode: addr=%h code=%b actual=%b expected=%b",
                     it.tag, addr, code, part_act, it.part_exp);
         end
      end
   end

   initial begin
      #50000000;
      mismatched++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      rst_n = 1'b1;
      // R7 idle state after reset
      drive(20'hE0000, 1'b0, 1'b1, 1'b1, 1'b1, 4'b1110, "R7 idle");
      // R1 region bounds for code E and C
      drive(20'hE0000, 1'b0, 1'b0, 1'b1, 1'b1, 4'b1110, "R1 E low edge");
      drive(20'hEFFFE, 1'b0, 1'b0, 1'b1, 1'b1, 4'b1110, "R1 E high edge");
      drive(20'hDFFFE, 1'b0, 1'b0, 1'b1, 1'b1, 4'b1110, "R1 below E");
      drive(20'hC0000, 1'b0, 1'b1, 1'b0, 1'b1, 4'b1100, "R1 C low edge");
      drive(20'hCFFFE, 1'b0, 1'b1, 1'b0, 1'b1, 4'b1100, "R1 C high edge");
      // R2 even byte, R3 odd byte and word
      drive(20'hE1234, 1'b1, 1'b0, 1'b1, 1'b0, 4'b1110, "R2 even byte");
      drive(20'hE1235, 1'b0, 1'b0, 1'b1, 1'b0, 4'b1110, "R3 odd byte");
      drive(20'hE1234, 1'b0, 1'b1, 1'b0, 1'b1, 4'b1110, "R3 even word");
      // R8 misaligned word
      drive(20'hE1235, 1'b0, 1'b0, 1'b1, 1'b1, 4'b1110, "R8 odd word");
      drive(20'h01235, 1'b0, 1'b1, 1'b0, 1'b1, 4'b1110, "R8 odd word outside");
      // R4 every block
      for (int k = 0; k < 8; k++)
         drive(20'hF0000 + 20'(k) * 20'h2000 + 20'h1FFF, 1'b0, 1'b0, 1'b1, 1'b0, 4'b1110, "R4 block");
      // R10 write into read-only region
      drive(20'hF4000, 1'b0, 1'b1, 1'b0, 1'b1, 4'b1110, "R10 rom write");
      // R5 pair placed at region F loses to blocks
      drive(20'hF2000, 1'b0, 1'b0, 1'b1, 1'b1, 4'b1111, "R5 rom priority read");
      drive(20'hF2000, 1'b0, 1'b1, 1'b0, 1'b1, 4'b1111, "R5 rom priority write");
      // R6 and R7 conflicting strobes
      drive(20'hE0000, 1'b0, 1'b0, 1'b0, 1'b1, 4'b1110, "R6 clash");
      drive(20'hF0000, 1'b0, 1'b0, 1'b0, 1'b0, 4'b1110, "R7 clash rom");
      // R9 partial decode spans E0000h..FFFFFh
      drive(20'hF8000, 1'b0, 1'b1, 1'b0, 1'b1, 4'b1110, "R9 upper half");
      drive(20'hFFFFE, 1'b0, 1'b0, 1'b1, 1'b1, 4'b1111, "R9 top");
      drive(20'hD0000, 1'b0, 1'b0, 1'b1, 1'b1, 4'b1110, "R9 miss");
      // R1 sweep of every code against random addresses
      for (int c = 0; c < 16; c++) begin
         for (int n = 0; n < 24; n++) begin
            logic [19:0] a;
            logic [1:0] st;
            a = 20'($urandom);
            if ($urandom_range(1, 0) == 1) a[19:16] = 4'(c);
            st = 2'($urandom);
            drive(a, 1'($urandom), st[0], st[1], 1'($urandom), 4'(c), "R1 sweep");
         end
      end
      drive(20'h00000, 1'b1, 1'b1, 1'b1, 1'b0, 4'b0000, "R7 final idle");
      @(posedge clk);
      @(posedge clk);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end
endmodule